// File: doc/BRIEF.md
# MIDI Clock and Transport Follower

This block lets a step sequencer follow an outside tempo source. It takes MIDI real-time messages that have already been parsed, or a plain 24-pulse-per-quarter-note input pin. From these it works out how fast the sequencer's step phase accumulator must advance. A free-running cycle timer measures the time between consecutive sync ticks. The measured interval is scaled by the step divider, and a multi-cycle divider turns it into a phase increment that is a little slower than nominal. Every divider-count of ticks the block asks the accumulator to reset its phase, so the two stay aligned.

The block also handles transport messages: Start, Stop, Continue and Song Position Pointer. From them it keeps a run flag and hands a pending step number to the step counter. A song position is folded into the active step window by modulo. The source and the divider each come from an attribute or parameter, and each can be overridden live.

Top module: `midi_clock_follower`

## Requirements
- R1: The active source is picked from `srcOverride` when it is nonzero and from `srcAttr` otherwise. The source codes are 0 internal, 1 external pulse, 2 MIDI from the selected device and port, and 3 MIDI from any device. A nonzero override selects the override minus 1, and values above 4 act as 4 (any device). With the internal source, neither MIDI clocks nor pulses are ticks.
- R2: The effective divider is `divOverride` when that is nonzero. Otherwise it is `divParam` when that is nonzero. Otherwise it is 12.
- R3: After reset, the first two accepted sync ticks only prime the measurement. They give no `ppqOut`, no `phaseReset` and no increment update. They do advance the tick count.
- R4: Every later accepted sync tick gives exactly one `ppqOut` pulse, one cycle wide, in the cycle after the tick is presented.
- R5: Each accepted tick increments the tick count. On a tick after priming, if the incremented count is at least the divider, `phaseReset` pulses together with `ppqOut` and the count returns to 0.
- R6: On each tick after priming, `phaseInc` becomes floor(68708739317 / P), saturated to 32 bits, no more than 45 cycles later. 68708739317 is 63.99·2^30. P = max(1, I·16·divider), where I is the number of clock cycles since the previous accepted tick.
- R7: Start (status 0xFA) sets the run flag, sets the count to the divider and queues step 0. The queued step is shown as a `stepLoad` pulse with `stepLoadValue` 0 in the next cycle. A song position still being resolved is then discarded.
- R8: Stop (0xFC) clears the run flag. Continue (0xFB) sets it.
- R9: Song Position Pointer (0xF2) zeroes the count. No more than 24 cycles later it pulses `stepLoad` with `firstStep + (6·(data2·128 + data1)) mod (lastStep − firstStep + 1)`. This assumes firstStep ≤ lastStep.
- R10: Transport messages take effect only while `obeyTransport` is 1. With it set at reset, the run flag clears in the first cycle after reset and stays clear until Start or Continue.
- R11: With the external source, a rising edge of `extPulse` is a sync tick, and a pulse held high counts once. With the external source and `obeyTransport` 0, the run flag is forced to 1.
- R12: A MIDI clock (0xF8) is a sync tick only from an accepted message. Source 3 accepts any device and port. Source 2 accepts only a message whose device and port both equal `selDevice` and `selPort`.
- R13: While the run flag is 0, sync ticks are neither counted nor measured, and they give no pulses.
- R14: During and right after reset the run flag is 1, `phaseInc` is 0, and `ppqOut`, `phaseReset` and `stepLoad` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the measurement timer advances once per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| msgValid | input | 1 | A parsed message is present this cycle |
| msgStatus | input | 8 | Status byte of the message |
| msgData1 | input | 7 | First data byte (song position low bits) |
| msgData2 | input | 7 | Second data byte (song position high bits) |
| msgDevice | input | DEV_W | Device tag of the message |
| msgPort | input | PORT_W | Port tag of the message |
| selDevice | input | DEV_W | Device selected for source 2 |
| selPort | input | PORT_W | Port selected for source 2 |
| extPulse | input | 1 | External 24 PPQ pulse |
| srcAttr | input | 2 | Source code used when no override is given |
| srcOverride | input | 3 | Live source override, 0 for none |
| divParam | input | DIV_W | Divider parameter, 0 means 12 |
| divOverride | input | DIV_W | Live divider override, 0 for none |
| obeyTransport | input | 1 | Honour Start, Stop, Continue and song position |
| firstStep | input | STEP_W | First step of the window |
| lastStep | input | STEP_W | Last step of the window |
| runFlag | output | 1 | Sequencer run state |
| phaseInc | output | 32 | Phase increment per cycle for the accumulator |
| phaseReset | output | 1 | One-cycle request to zero the phase |
| ppqOut | output | 1 | One-cycle 24 PPQ pulse per accepted tick |
| stepLoad | output | 1 | One-cycle strobe: load `stepLoadValue` as the next step |
| stepLoadValue | output | STEP_W | Queued step number |

## Verification
The bench keeps the default parameters. With DIV_W 8 and the default divider of 12, a full divide cycle, the override down to 3 and 4, and the Start-driven reset all fit in a few hundred ticks. STEP_W 5 allows song-position windows of length 1 up to the full 32 steps, which exercises wrap-around of the modulo. TIMER_W 16 measures tick spacings of 20 to 100 cycles exactly, so every expected increment is an integer quotient the bench can compute itself.

// File: rtl/midiclk_pkg.sv
package midiclk_pkg;

  localparam logic [7:0] ST_CLOCK   = 8'hF8;
  localparam logic [7:0] ST_START   = 8'hFA;
  localparam logic [7:0] ST_CONT    = 8'hFB;
  localparam logic [7:0] ST_STOP    = 8'hFC;
  localparam logic [7:0] ST_SONGPOS = 8'hF2;

  // 63.99 * 2^30, the slowed increment numerator
  localparam int unsigned INC_NUM_W = 37;
  localparam logic [INC_NUM_W-1:0] INC_NUMERATOR = 37'd68708739317;

  typedef enum logic [1:0] {
    SRC_INTERNAL = 2'd0,
    SRC_EXTERNAL = 2'd1,
    SRC_PORT_MIDI = 2'd2,
    SRC_ANY_MIDI = 2'd3
  } srcSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic measure;     // accepted tick: restamp interval timer
    logic computeInc;  // primed tick: start increment division
    logic songPos;     // start song position folding
    logic loadZero;    // Start: queue step 0, drop pending song position
  } dpStrobe_t;

endpackage

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int NUM_W = 37,
  parameter int DEN_W = 28,
  parameter bit RETURN_REM = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic done,
  output logic [(RETURN_REM ? DEN_W : NUM_W)-1:0] result
);

  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] work;
  logic [DEN_W-1:0] part;
  logic [DEN_W-1:0] denHold;
  logic [CNT_W-1:0] left;
  logic [DEN_W:0]   trial;
  logic             fits;

  assign trial = {part, work[NUM_W-1]};
  assign fits  = trial >= {1'b0, denHold};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      work    <= '0;
      part    <= '0;
      denHold <= '0;
      left    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        work    <= numer;
        part    <= '0;
        denHold <= denom;
        left    <= CNT_W'(NUM_W);
      end else if (left != '0) begin
        part <= fits ? DEN_W'(trial - {1'b0, denHold}) : DEN_W'(trial);
        work <= {work[NUM_W-2:0], fits};
        left <= left - CNT_W'(1);
        if (left == CNT_W'(1)) done <= 1'b1;
      end
    end
  end

  generate
    if (RETURN_REM) begin : g_rem
      assign result = part;
    end else begin : g_quot
      assign result = work;
    end
  endgenerate

endmodule

// File: rtl/midiclk_ctrl.sv
module midiclk_ctrl
  import midiclk_pkg::*;
#(
  parameter int DEV_W = 4,
  parameter int PORT_W = 2,
  parameter int DIV_W = 8,
  parameter int DIV_DEFAULT = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic msgValid,
  input  logic [7:0] msgStatus,
  input  logic [DEV_W-1:0] msgDevice,
  input  logic [PORT_W-1:0] msgPort,
  input  logic [DEV_W-1:0] selDevice,
  input  logic [PORT_W-1:0] selPort,
  input  logic extPulse,
  input  logic [1:0] srcAttr,
  input  logic [2:0] srcOverride,
  input  logic [DIV_W-1:0] divParam,
  input  logic [DIV_W-1:0] divOverride,
  input  logic obeyTransport,
  output dpStrobe_t strobe,
  output logic [DIV_W-1:0] effDiv,
  output logic runFlag,
  output logic ppqOut,
  output logic phaseReset
);

  localparam int CW = DIV_W + 1;

  srcSel_t srcNow;
  logic [CW-1:0] count, countNext;
  logic [1:0] primeCnt;
  logic extPrev, startup;
  logic midiMatch, extRise, syncTick, primed, reachDiv;
  logic transportOk, isStart, isStop, isCont, isSongPos;

  always_comb begin
    case (srcOverride)
      3'd0:    srcNow = srcSel_t'(srcAttr);
      3'd1:    srcNow = SRC_INTERNAL;
      3'd2:    srcNow = SRC_EXTERNAL;
      3'd3:    srcNow = SRC_PORT_MIDI;
      default: srcNow = SRC_ANY_MIDI;
    endcase
  end

  always_comb begin
    if (divOverride != '0)   effDiv = divOverride;
    else if (divParam != '0) effDiv = divParam;
    else                     effDiv = DIV_W'(DIV_DEFAULT);
  end

  assign midiMatch = msgValid &&
                     ((srcNow == SRC_ANY_MIDI) ||
                      (srcNow == SRC_PORT_MIDI && msgDevice == selDevice && msgPort == selPort));
  assign extRise   = (srcNow == SRC_EXTERNAL) && extPulse && !extPrev;
  assign syncTick  = runFlag && ((midiMatch && msgStatus == ST_CLOCK) || extRise);

  assign transportOk = midiMatch && obeyTransport;
  assign isStart     = transportOk && msgStatus == ST_START;
  assign isStop      = transportOk && msgStatus == ST_STOP;
  assign isCont      = transportOk && msgStatus == ST_CONT;
  assign isSongPos   = transportOk && msgStatus == ST_SONGPOS;

  assign primed    = primeCnt == 2'd2;
  assign countNext = count + CW'(1);
  assign reachDiv  = countNext >= {1'b0, effDiv};

  assign strobe.measure    = syncTick;
  assign strobe.computeInc = syncTick && primed;
  assign strobe.songPos    = isSongPos;
  assign strobe.loadZero   = isStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runFlag    <= 1'b1;
      startup    <= 1'b1;
      count      <= '0;
      primeCnt   <= '0;
      extPrev    <= 1'b0;
      ppqOut     <= 1'b0;
      phaseReset <= 1'b0;
    end else begin
      extPrev    <= extPulse;
      startup    <= 1'b0;
      ppqOut     <= 1'b0;
      phaseReset <= 1'b0;
      if (startup && obeyTransport) runFlag <= 1'b0;
      if (syncTick) begin
        if (!primed) begin
          primeCnt <= primeCnt + 2'd1;
          count    <= countNext;
        end else begin
          ppqOut <= 1'b1;
          if (reachDiv) begin
            phaseReset <= 1'b1;
            count      <= '0;
          end else begin
            count <= countNext;
          end
        end
      end
      if (isStart) begin
        runFlag <= 1'b1;
        count   <= {1'b0, effDiv};
      end
      if (isStop) runFlag <= 1'b0;
      if (isCont) runFlag <= 1'b1;
      if (isSongPos) count <= '0;
      if (srcNow == SRC_EXTERNAL && !obeyTransport) runFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/midiclk_dp.sv
module midiclk_dp
  import midiclk_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int STEP_W = 5,
  parameter int TIMER_W = 16
) (
  input  logic clk,
  input  logic rstN,
  input  dpStrobe_t strobe,
  input  logic [DIV_W-1:0] effDiv,
  input  logic [6:0] spData1,
  input  logic [6:0] spData2,
  input  logic [STEP_W-1:0] firstStep,
  input  logic [STEP_W-1:0] lastStep,
  output logic [31:0] phaseInc,
  output logic stepLoad,
  output logic [STEP_W-1:0] stepLoadValue
);

  localparam int PROD_W = TIMER_W + DIV_W;
  localparam int PER_W  = PROD_W + 4;
  localparam int POS_W  = 17;
  localparam int LEN_W  = STEP_W + 1;

  logic [TIMER_W-1:0] timer, lastStamp, intervalNow;
  logic [PROD_W-1:0]  prod;
  logic [PER_W-1:0]   periodDen;
  logic [INC_NUM_W-1:0] incQuot;
  logic incDone;

  logic [POS_W-1:0] songPosNum;
  logic [LEN_W-1:0] windowLen, sppRem;
  logic [STEP_W-1:0] firstLatched;
  logic sppDone, sppLive;

  assign intervalNow = timer - lastStamp;
  assign prod        = PROD_W'(intervalNow) * PROD_W'(effDiv);
  assign periodDen   = (prod == '0) ? PER_W'(1) : {prod, 4'b0000};

  assign songPosNum = POS_W'({spData2, spData1}) * POS_W'(6);
  assign windowLen  = LEN_W'(lastStep) - LEN_W'(firstStep) + LEN_W'(1);

  seq_divider #(.NUM_W(INC_NUM_W), .DEN_W(PER_W), .RETURN_REM(1'b0)) u_incDiv (
    .clk(clk), .rstN(rstN), .start(strobe.computeInc),
    .numer(INC_NUMERATOR), .denom(periodDen),
    .done(incDone), .result(incQuot)
  );

  seq_divider #(.NUM_W(POS_W), .DEN_W(LEN_W), .RETURN_REM(1'b1)) u_sppDiv (
    .clk(clk), .rstN(rstN), .start(strobe.songPos),
    .numer(songPosNum), .denom(windowLen),
    .done(sppDone), .result(sppRem)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer         <= '0;
      lastStamp     <= '0;
      phaseInc      <= '0;
      firstLatched  <= '0;
      sppLive       <= 1'b0;
      stepLoad      <= 1'b0;
      stepLoadValue <= '0;
    end else begin
      timer    <= timer + TIMER_W'(1);
      stepLoad <= 1'b0;
      if (strobe.measure) lastStamp <= timer;
      if (incDone) phaseInc <= (incQuot[INC_NUM_W-1:32] != '0) ? 32'hFFFF_FFFF : incQuot[31:0];
      if (strobe.songPos) begin
        sppLive      <= 1'b1;
        firstLatched <= firstStep;
      end
      if (strobe.loadZero) begin
        sppLive       <= 1'b0;
        stepLoad      <= 1'b1;
        stepLoadValue <= '0;
      end else if (sppDone && sppLive) begin
        sppLive       <= 1'b0;
        stepLoad      <= 1'b1;
        stepLoadValue <= STEP_W'({1'b0, firstLatched} + sppRem);
      end
    end
  end

endmodule

// File: rtl/midi_clock_follower.sv
module midi_clock_follower
  import midiclk_pkg::*;
#(
  parameter int DEV_W = 4,
  parameter int PORT_W = 2,
  parameter int DIV_W = 8,
  parameter int STEP_W = 5,
  parameter int TIMER_W = 16,
  parameter int DIV_DEFAULT = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic msgValid,
  input  logic [7:0] msgStatus,
  input  logic [6:0] msgData1,
  input  logic [6:0] msgData2,
  input  logic [DEV_W-1:0] msgDevice,
  input  logic [PORT_W-1:0] msgPort,
  input  logic [DEV_W-1:0] selDevice,
  input  logic [PORT_W-1:0] selPort,
  input  logic extPulse,
  input  logic [1:0] srcAttr,
  input  logic [2:0] srcOverride,
  input  logic [DIV_W-1:0] divParam,
  input  logic [DIV_W-1:0] divOverride,
  input  logic obeyTransport,
  input  logic [STEP_W-1:0] firstStep,
  input  logic [STEP_W-1:0] lastStep,
  output logic runFlag,
  output logic [31:0] phaseInc,
  output logic phaseReset,
  output logic ppqOut,
  output logic stepLoad,
  output logic [STEP_W-1:0] stepLoadValue
);

  dpStrobe_t strobe;
  logic [DIV_W-1:0] effDiv;

  midiclk_ctrl #(
    .DEV_W(DEV_W), .PORT_W(PORT_W), .DIV_W(DIV_W), .DIV_DEFAULT(DIV_DEFAULT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .msgValid(msgValid), .msgStatus(msgStatus),
    .msgDevice(msgDevice), .msgPort(msgPort),
    .selDevice(selDevice), .selPort(selPort),
    .extPulse(extPulse), .srcAttr(srcAttr), .srcOverride(srcOverride),
    .divParam(divParam), .divOverride(divOverride),
    .obeyTransport(obeyTransport),
    .strobe(strobe), .effDiv(effDiv),
    .runFlag(runFlag), .ppqOut(ppqOut), .phaseReset(phaseReset)
  );

  midiclk_dp #(
    .DIV_W(DIV_W), .STEP_W(STEP_W), .TIMER_W(TIMER_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .effDiv(effDiv),
    .spData1(msgData1), .spData2(msgData2),
    .firstStep(firstStep), .lastStep(lastStep),
    .phaseInc(phaseInc), .stepLoad(stepLoad), .stepLoadValue(stepLoadValue)
  );

endmodule

// File: rtl/midi_clock_follower_chk.sv
module midi_clock_follower_chk #(
  parameter int STEP_W = 5
) (
  input logic clk,
  input logic rstN,
  input logic msgValid,
  input logic [7:0] msgStatus,
  input logic [2:0] srcOverride,
  input logic obeyTransport,
  input logic runFlag,
  input logic ppqOut,
  input logic phaseReset,
  input logic stepLoad,
  input logic [STEP_W-1:0] stepLoadValue
);

  AST_START_LOADS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgStatus == 8'hFA && obeyTransport && srcOverride == 3'd4)
    |=> (runFlag && stepLoad && stepLoadValue == '0)); // R7

  AST_STOP_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgStatus == 8'hFC && obeyTransport && srcOverride == 3'd4)
    |=> !runFlag); // R8

  AST_EXT_FORCES_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (srcOverride == 3'd2 && !obeyTransport) |=> runFlag); // R11

  AST_STOPPED_NO_PPQ: assert property (@(posedge clk) disable iff (!rstN)
    !runFlag |=> !ppqOut); // R13

  AST_RESET_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    phaseReset |-> ppqOut); // R5

endmodule

bind midi_clock_follower midi_clock_follower_chk #(.STEP_W(STEP_W)) u_chk (.*);

// File: tb/midi_clock_follower_test.sv
`timescale 1ns/1ps
module midi_clock_follower_test;

  localparam longint KNUM = 64'd68708739317;

  typedef struct packed {
    logic [6:0] d1;
    logic [6:0] d2;
    logic [4:0] first;
    logic [4:0] last;
    logic [4:0] expect_;
  } sppVec_t;

  localparam sppVec_t SPP_TABLE [7] = '{
    '{7'd0,   7'd0,   5'd0, 5'd7,  5'd0},
    '{7'd1,   7'd0,   5'd0, 5'd7,  5'd6},
    '{7'd3,   7'd0,   5'd2, 5'd5,  5'd4},
    '{7'd0,   7'd1,   5'd3, 5'd9,  5'd8},
    '{7'd127, 7'd127, 5'd0, 5'd31, 5'd26},
    '{7'd5,   7'd0,   5'd4, 5'd4,  5'd4},
    '{7'd10,  7'd0,   5'd1, 5'd6,  5'd1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msgValid = 1'b0;
  logic [7:0] msgStatus = 8'h00;
  logic [6:0] msgData1 = '0, msgData2 = '0;
  logic [3:0] msgDevice = '0, selDevice = 4'd5;
  logic [1:0] msgPort = '0, selPort = 2'd1;
  logic extPulse = 1'b0;
  logic [1:0] srcAttr = 2'd2;
  logic [2:0] srcOverride = 3'd0;
  logic [7:0] divParam = 8'd0, divOverride = 8'd0;
  logic obeyTransport = 1'b0;
  logic [4:0] firstStep = 5'd0, lastStep = 5'd7;
  logic runFlag, phaseReset, ppqOut, stepLoad;
  logic [31:0] phaseInc;
  logic [4:0] stepLoadValue;

  int checks = 0;
  int fails = 0;
  logic seenPpq, seenRst, seenLoad, seenRun;
  logic [4:0] seenVal;

  always #2 clk = ~clk;

  midi_clock_follower uut (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgStatus(msgStatus),
    .msgData1(msgData1), .msgData2(msgData2), .msgDevice(msgDevice), .msgPort(msgPort),
    .selDevice(selDevice), .selPort(selPort), .extPulse(extPulse),
    .srcAttr(srcAttr), .srcOverride(srcOverride), .divParam(divParam),
    .divOverride(divOverride), .obeyTransport(obeyTransport),
    .firstStep(firstStep), .lastStep(lastStep), .runFlag(runFlag),
    .phaseInc(phaseInc), .phaseReset(phaseReset), .ppqOut(ppqOut),
    .stepLoad(stepLoad), .stepLoadValue(stepLoadValue)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sendMsg(input logic [7:0] st, input logic [6:0] d1, input logic [6:0] d2,
                         input logic [3:0] dev, input logic [1:0] prt);
    @(negedge clk);
    msgValid = 1'b1; msgStatus = st; msgData1 = d1; msgData2 = d2;
    msgDevice = dev; msgPort = prt;
    @(negedge clk);
    seenPpq = ppqOut; seenRst = phaseReset; seenLoad = stepLoad;
    seenVal = stepLoadValue; seenRun = runFlag;
    msgValid = 1'b0;
  endtask

  task automatic waitLoad(output logic found, output logic [4:0] val);
    found = 1'b0; val = '0;
    for (int i = 0; i < 40 && !found; i++) begin
      @(negedge clk);
      if (stepLoad) begin found = 1'b1; val = stepLoadValue; end
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    logic found;
    logic [4:0] val;

    // R14 reset state
    idle(3);
    chk("R14 run in reset", runFlag, 1);
    chk("R14 inc in reset", phaseInc, 0);
    chk("R14 pulses in reset", {ppqOut, phaseReset, stepLoad}, 0);
    rstN = 1'b1;
    idle(3);
    chk("R14 run after reset", runFlag, 1);
    chk("R14 inc after reset", phaseInc, 0);

    // R10 stop ignored without obey
    sendMsg(8'hFC, 0, 0, 4'd5, 2'd1);
    idle(2);
    chk("R10 stop ignored", runFlag, 1);

    // R12 mismatched device or port must not tick (shown via priming below)
    sendMsg(8'hF8, 0, 0, 4'd6, 2'd1);
    chk("R12 wrong device", seenPpq, 0);
    sendMsg(8'hF8, 0, 0, 4'd5, 2'd2);
    chk("R12 wrong port", seenPpq, 0);
    sendMsg(8'hF8, 0, 0, 4'd3, 2'd0);
    chk("R12 both wrong", seenPpq, 0);
    idle(10);

    // R2/R3/R4/R5/R6: divider 12, spacing 100
    for (int k = 1; k <= 12; k++) begin
      sendMsg(8'hF8, 0, 0, 4'd5, 2'd1);
      chk($sformatf("R3/R4 ppq tick %0d", k), seenPpq, (k >= 3) ? 1 : 0);
      chk($sformatf("R2/R5 reset tick %0d", k), seenRst, (k == 12) ? 1 : 0);
      idle(44);
      if (k >= 3) chk($sformatf("R6 inc tick %0d", k), phaseInc, KNUM / (100 * 16 * 12));
      else chk($sformatf("R3 inc primed %0d", k), phaseInc, 0);
      idle(100 - 46);
    end

    // R2 override 4, then R6 interval 50
    divOverride = 8'd4;
    for (int k = 1; k <= 6; k++) begin
      sendMsg(8'hF8, 0, 0, 4'd5, 2'd1);
      chk($sformatf("R2/R5 override reset %0d", k), seenRst, (k == 4) ? 1 : 0);
      idle(44);
      chk($sformatf("R6 inc override %0d", k), phaseInc, KNUM / ((k == 6 ? 50 : 100) * 16 * 4));
      idle(((k >= 5) ? 50 : 100) - 46);
    end
    divOverride = 8'd0;

    // R1/R11 external source
    srcOverride = 3'd2;
    idle(2);
    chk("R11 run forced", runFlag, 1);
    @(negedge clk); extPulse = 1'b1;
    @(negedge clk); chk("R11 ext edge ticks", ppqOut, 1);
    @(negedge clk); chk("R11 held pulse once", ppqOut, 0);
    idle(3); extPulse = 1'b0;
    sendMsg(8'hF8, 0, 0, 4'd5, 2'd1);
    chk("R1 midi ignored on ext", seenPpq, 0);
    srcOverride = 3'd7;
    sendMsg(8'hF8, 0, 0, 4'd9, 2'd3);
    chk("R1 clamp to any device", seenPpq, 1);
    srcOverride = 3'd1;
    sendMsg(8'hF8, 0, 0, 4'd5, 2'd1);
    chk("R1 internal no tick", seenPpq, 0);
    srcOverride = 3'd3;
    sendMsg(8'hF8, 0, 0, 4'd5, 2'd1);
    chk("R12 matching device", seenPpq, 1);
    @(negedge clk); extPulse = 1'b1;
    @(negedge clk); chk("R1 ext ignored on midi", ppqOut, 0);
    extPulse = 1'b0;
    srcOverride = 3'd0;

    // R10 obey set across reset
    obeyTransport = 1'b1; srcAttr = 2'd3;
    @(negedge clk); rstN = 1'b0;
    idle(2); rstN = 1'b1;
    idle(3);
    chk("R10 run cleared with obey", runFlag, 0);
    for (int k = 0; k < 3; k++) begin
      sendMsg(8'hF8, 0, 0, 4'd1, 2'd0);
      chk("R13 stopped no ppq", seenPpq, 0);
      idle(18);
    end
    sendMsg(8'hFA, 0, 0, 4'd1, 2'd0);
    chk("R7 start run", seenRun, 1);
    chk("R7 start load", seenLoad, 1);
    chk("R7 start value", seenVal, 0);
    for (int k = 1; k <= 3; k++) begin
      idle(18);
      sendMsg(8'hF8, 0, 0, 4'd1, 2'd0);
      chk($sformatf("R13 ppq after start %0d", k), seenPpq, (k == 3) ? 1 : 0);
      chk($sformatf("R7 reset after start %0d", k), seenRst, (k == 3) ? 1 : 0);
    end
    sendMsg(8'hFC, 0, 0, 4'd1, 2'd0);
    chk("R8 stop", seenRun, 0);
    sendMsg(8'hF8, 0, 0, 4'd1, 2'd0);
    chk("R8 stopped tick", seenPpq, 0);
    sendMsg(8'hFB, 0, 0, 4'd1, 2'd0);
    chk("R8 continue", seenRun, 1);
    sendMsg(8'hF8, 0, 0, 4'd1, 2'd0);
    chk("R8 running tick", seenPpq, 1);
    chk("R8 no reset", seenRst, 0);

    // R9 song position table
    foreach (SPP_TABLE[i]) begin
      firstStep = SPP_TABLE[i].first;
      lastStep  = SPP_TABLE[i].last;
      sendMsg(8'hF2, SPP_TABLE[i].d1, SPP_TABLE[i].d2, 4'd1, 2'd0);
      waitLoad(found, val);
      chk($sformatf("R9 spp load %0d", i), found, 1);
      chk($sformatf("R9 spp value %0d", i), val, SPP_TABLE[i].expect_);
    end

    // R9 count zeroed by song position (divider 3)
    firstStep = 5'd0; lastStep = 5'd7;
    divOverride = 8'd3;
    for (int k = 1; k <= 3; k++) begin
      idle(18);
      sendMsg(8'hF8, 0, 0, 4'd1, 2'd0);
      chk($sformatf("R9 count zeroed %0d", k), seenRst, (k == 3) ? 1 : 0);
    end

    // R7 start discards pending song position
    sendMsg(8'hF2, 7'd3, 7'd0, 4'd1, 2'd0);
    sendMsg(8'hFA, 0, 0, 4'd1, 2'd0);
    chk("R7 start over spp value", seenVal, 0);
    waitLoad(found, val);
    chk("R7 spp discarded", found, 0);

    // R10 obey off ignores transport
    obeyTransport = 1'b0;
    sendMsg(8'hFC, 0, 0, 4'd1, 2'd0);
    idle(1);
    chk("R10 stop ignored", runFlag, 1);
    sendMsg(8'hF2, 7'd1, 7'd0, 4'd1, 2'd0);
    waitLoad(found, val);
    chk("R10 spp ignored", found, 0);

    finishRun();
  end

endmodule